// File: doc/BRIEF.md
# UART Interrupt Pending and Mask Unit

This block gathers the four interrupt causes of one UART channel (receive, error, transmit, modem) into a sticky source register. It masks that register to form a pending register, and it raises one level-sensitive interrupt line while any pending bit is set. Causes from the receive path, the error logic and the modem lines enter as one-cycle set pulses. The transmit cause is produced inside the block. The block compares the transmit FIFO fill count with a threshold taken from the 3-bit transmit trigger field of the FIFO control register. The field is scaled by a factor that depends on the channel number, which is a parameter.

Software reaches the three registers through a small word port. The port has a 2-bit register select, a write strobe, 4 bits of write data and combinational read data. Writing ones to the source register or to the pending register clears those cause bits. Writing to the mask register sets the mask, and pending and the interrupt line follow it at the same clock edge. The FIFOs and the serial datapath sit outside the block.

Top module: `uirq_unit`

## Requirements
- R1: Source bit positions are 0 receive, 1 error, 2 transmit, 3 modem. A one on `evt_set[i]` at a clock edge sets source bit i, and the bit stays set until software clears it.
- R2: The pending register equals source AND NOT mask after every edge. `irq_o` is registered and is high exactly when the pending register is nonzero. All three follow a set event or a write at the same clock edge.
- R3: A write with select 1 (pending) clears every bit whose write-data bit is 1, in both the pending and the source register. Zero bits leave both registers unchanged.
- R4: A write with select 0 (source) clears every source bit whose write-data bit is 1.
- R5: A write with select 2 loads the mask. Pending and `irq_o` reflect the new mask after that same edge, and reads with select 2 return the mask.
- R6: The transmit threshold is `tx_level` times a channel factor: 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel.
- R7: While `fifo_en` is 1 and `tx_count` is at or below the threshold, source bit 2 is set at each edge. While `fifo_en` is 0, or the count is above the threshold, nothing sets source bit 2.
- R8: A set of a source bit, from `evt_set` or from the transmit trigger, wins over a software clear of the same bit in the same cycle.
- R9: Reset (`rst_n` low, asynchronous) zeroes the source, pending and mask registers and drives `irq_o` low.
- R10: Select 3 is reserved. Writes to it change no register, and reads of it return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 source, 1 pending, 2 mask, 3 reserved |
| reg_wdata | input | 4 | Write data, one bit per cause |
| reg_rdata | output | 4 | Read data of the selected register |
| evt_set | input | 4 | Hardware cause set pulses, indexed by source bit |
| fifo_en | input | 1 | FIFO mode enable from FIFO control |
| tx_level | input | 3 | Transmit trigger field, FIFO control bits [10:8] |
| tx_count | input | CNT_W | Current transmit FIFO fill count |
| irq_o | output | 1 | Level interrupt request |

## Verification
If the source register holds a wrong bit, the mismatch shows on the read port and on `irq_o` one edge after the faulty event or write. The reason is that pending and the line are recomputed from next-state values, with no extra stage. A bad threshold shows only at the boundary counts. The bench therefore drives counts exactly at and one above the scaled level. A lost priority between set and clear shows as a cleared bit one edge after a cycle where both act on it.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int unsigned NSRC    = 4;
  localparam int unsigned SRC_RX  = 0;
  localparam int unsigned SRC_ERR = 1;
  localparam int unsigned SRC_TX  = 2;
  localparam int unsigned SRC_MDM = 3;

  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_PEND = 2'd1,
    SEL_MASK = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

  // Channel-dependent multiplier of the transmit trigger field.
  function automatic int unsigned trig_scale(input int unsigned ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/uirq_tx_trig.sv
module uirq_tx_trig #(
  parameter int unsigned CHANNEL = 0,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned LVL_W   = 3
) (
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [CNT_W-1:0] tx_count,
  output logic             tx_hit
);
  localparam int unsigned SCALE = uirq_pkg::trig_scale(CHANNEL);
  localparam int unsigned TH_W  = LVL_W + 6;
  localparam int unsigned CMP_W = (CNT_W > TH_W) ? CNT_W : TH_W;

  logic [CMP_W-1:0] thresh;
  logic [CMP_W-1:0] count_ext;

  generate
    if (SCALE == 0) begin : g_zero
      assign thresh = '0;
    end else begin : g_scaled
      assign thresh = CMP_W'(tx_level) * CMP_W'(SCALE);
    end
  endgenerate

  assign count_ext = CMP_W'(tx_count);
  assign tx_hit    = fifo_en && (count_ext <= thresh);
endmodule

// File: rtl/uirq_src_reg.sv
module uirq_src_reg #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] src_q,
  output logic [NSRC-1:0] src_nxt
);
  logic src_en;

  always_comb begin
    src_en  = (|set_i) || (|clr_i);
    src_nxt = (src_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
    end else if (src_en) begin
      src_q <= src_nxt;
    end
  end
endmodule

// File: rtl/uirq_mask_pend.sv
module uirq_mask_pend #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic [NSRC-1:0] src_nxt,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] pend_q,
  output logic            irq_o
);
  logic [NSRC-1:0] mask_nxt;
  logic [NSRC-1:0] pend_nxt;

  always_comb begin
    mask_nxt = mask_we ? mask_wdata : mask_q;
    pend_nxt = src_nxt & ~mask_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      irq_o  <= |pend_nxt;
    end
  end
endmodule

// File: rtl/uirq_unit.sv
module uirq_unit #(
  parameter int unsigned CHANNEL = 0,
  parameter int unsigned CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_sel,
  input  logic [3:0]       reg_wdata,
  output logic [3:0]       reg_rdata,
  input  logic [3:0]       evt_set,
  input  logic             fifo_en,
  input  logic [2:0]       tx_level,
  input  logic [CNT_W-1:0] tx_count,
  output logic             irq_o
);
  import uirq_pkg::*;

  logic            tx_hit;
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] clr_vec;
  logic            mask_we;
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] src_nxt;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] pend_q;

  uirq_tx_trig #(.CHANNEL(CHANNEL), .CNT_W(CNT_W), .LVL_W(3)) u_trig (
    .fifo_en  (fifo_en),
    .tx_level (tx_level),
    .tx_count (tx_count),
    .tx_hit   (tx_hit)
  );

  always_comb begin
    set_vec         = evt_set;
    set_vec[SRC_TX] = evt_set[SRC_TX] | tx_hit;
    clr_vec         = '0;
    mask_we         = 1'b0;
    if (reg_wr_en) begin
      case (reg_sel_e'(reg_sel))
        SEL_SRC, SEL_PEND: clr_vec = reg_wdata;
        SEL_MASK:          mask_we = 1'b1;
        default:           ;
      endcase
    end
  end

  uirq_src_reg #(.NSRC(NSRC)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .src_q   (src_q),
    .src_nxt (src_nxt)
  );

  uirq_mask_pend #(.NSRC(NSRC)) u_mp (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_we    (mask_we),
    .mask_wdata (reg_wdata),
    .src_nxt    (src_nxt),
    .mask_q     (mask_q),
    .pend_q     (pend_q),
    .irq_o      (irq_o)
  );

  always_comb begin
    case (reg_sel_e'(reg_sel))
      SEL_SRC:  reg_rdata = src_q;
      SEL_PEND: reg_rdata = pend_q;
      SEL_MASK: reg_rdata = mask_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uirq_unit_chk.sv
module uirq_unit_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [1:0]       reg_sel,
  input logic [3:0]       reg_wdata,
  input logic [3:0]       evt_set,
  input logic             fifo_en,
  input logic [CNT_W-1:0] tx_count,
  input logic [3:0]       src_q,
  input logic [3:0]       mask_q,
  input logic [3:0]       pend_q,
  input logic             irq_o
);
  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_set[0] |=> src_q[0]); // R1

  AST_PEND_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q == (src_q & ~mask_q)); // R2

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (pend_q != 4'd0)); // R2

  AST_PEND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_sel == 2'd1 && reg_wdata[0] && !evt_set[0]) |=> !src_q[0]); // R3

  AST_SRC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_sel == 2'd0 && reg_wdata[3] && !evt_set[3]) |=> !src_q[3]); // R4

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_sel == 2'd2) |=> $stable(mask_q)); // R5

  AST_TX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && tx_count == '0) |=> src_q[2]); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set[1] && reg_wr_en && reg_wdata[1]) |=> src_q[1]); // R8

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RST_IDLE: assert (irq_o == 1'b0 && src_q == 4'd0 && mask_q == 4'd0); // R9
    end
  end
endmodule

bind uirq_unit uirq_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .evt_set   (evt_set),
  .fifo_en   (fifo_en),
  .tx_count  (tx_count),
  .src_q     (src_q),
  .mask_q    (mask_q),
  .pend_q    (pend_q),
  .irq_o     (irq_o)
);

// File: tb/uirq_unit_bench.sv
module uirq_unit_bench;
  localparam int unsigned CH    = 1;
  localparam int unsigned FAC   = (CH == 0) ? 32 : ((CH == 1 || CH == 4) ? 8 : ((CH == 2 || CH == 3) ? 2 : 0));
  localparam logic [7:0]  T3    = 8'(3 * FAC);
  localparam logic [7:0]  T7    = 8'(7 * FAC);
  localparam int          NVEC  = 22;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr_en;
  logic [1:0] reg_sel;
  logic [3:0] reg_wdata;
  logic [3:0] reg_rdata;
  logic [3:0] evt_set;
  logic       fifo_en;
  logic [2:0] tx_level;
  logic [7:0] tx_count;
  logic       irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  uirq_unit #(.CHANNEL(CH), .CNT_W(8)) u_uirq_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .fifo_en(fifo_en), .tx_level(tx_level), .tx_count(tx_count), .irq_o(irq_o)
  );

  // Vector layout: wr sel wdata evt fen lvl cnt | exp src pend mask irq
  function automatic logic [35:0] v(input logic wr, input logic [1:0] sel,
      input logic [3:0] wd, input logic [3:0] ev, input logic fen,
      input logic [2:0] lvl, input logic [7:0] cnt, input logic [3:0] es,
      input logic [3:0] ep, input logic [3:0] em, input logic ei);
    return {wr, sel, wd, ev, fen, lvl, cnt, es, ep, em, ei};
  endfunction

  localparam logic [35:0] VEC [NVEC] = '{
    v(0,0,4'h0,4'h1,0,0,0,    4'h1,4'h1,4'h0,1), // 0  R1 rx set
    v(0,0,4'h0,4'h8,0,0,0,    4'h9,4'h9,4'h0,1), // 1  R1 modem set
    v(1,3,4'hF,4'h0,0,0,0,    4'h9,4'h9,4'h0,1), // 2  R10 reserved write
    v(1,1,4'h0,4'h0,0,0,0,    4'h9,4'h9,4'h0,1), // 3  R3 zero write
    v(1,2,4'h9,4'h0,0,0,0,    4'h9,4'h0,4'h9,0), // 4  R5 mask all
    v(1,2,4'h1,4'h0,0,0,0,    4'h9,4'h8,4'h1,1), // 5  R5 R2 unmask modem
    v(1,1,4'h8,4'h0,0,0,0,    4'h1,4'h0,4'h1,0), // 6  R3 pend clear
    v(1,0,4'h1,4'h0,0,0,0,    4'h0,4'h0,4'h1,0), // 7  R4 src clear
    v(1,2,4'h0,4'h0,0,0,0,    4'h0,4'h0,4'h0,0), // 8  R5 mask off
    v(1,0,4'h2,4'h2,0,0,0,    4'h2,4'h2,4'h0,1), // 9  R8 set vs src clear
    v(1,1,4'h2,4'h2,0,0,0,    4'h2,4'h2,4'h0,1), // 10 R8 set vs pend clear
    v(1,1,4'h2,4'h0,0,0,0,    4'h0,4'h0,4'h0,0), // 11 R3 error cleared
    v(0,0,4'h0,4'h0,1,3,T3+8'd1,4'h0,4'h0,4'h0,0),// 12 R6 above level 3
    v(0,0,4'h0,4'h0,1,3,T3,   4'h4,4'h4,4'h0,1), // 13 R6 at level 3
    v(1,0,4'h4,4'h0,0,0,0,    4'h0,4'h0,4'h0,0), // 14 R4 tx clear
    v(0,0,4'h0,4'h0,0,7,0,    4'h0,4'h0,4'h0,0), // 15 R7 fifo disabled
    v(0,0,4'h0,4'h0,1,0,0,    4'h4,4'h4,4'h0,1), // 16 R7 level 0 empty
    v(1,0,4'h4,4'h0,1,0,1,    4'h0,4'h0,4'h0,0), // 17 R7 count above 0
    v(0,0,4'h0,4'h0,1,7,T7+8'd1,4'h0,4'h0,4'h0,0),// 18 R6 above level 7
    v(0,0,4'h0,4'h0,1,7,T7,   4'h4,4'h4,4'h0,1), // 19 R6 at level 7
    v(1,0,4'h4,4'h0,1,7,T7,   4'h4,4'h4,4'h0,1), // 20 R8 tx set wins
    v(1,1,4'hF,4'h0,0,0,0,    4'h0,4'h0,4'h0,0)  // 21 R3 clear all
  };

  function automatic string vtag(input int i);
    case (i)
      0, 1:               return "R1";
      2:                  return "R10";
      3, 6, 11, 21:       return "R3";
      4, 5, 8:            return "R5";
      7, 14:              return "R4";
      9, 10, 20:          return "R8";
      12, 13, 18, 19:     return "R6";
      default:            return "R7";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    reg_wr_en = 1'b0; reg_wdata = '0; evt_set = '0;
    fifo_en = 1'b0; tx_level = '0; tx_count = '0;
  endtask

  task automatic read_all(input string req, input logic [3:0] es,
      input logic [3:0] ep, input logic [3:0] em, input logic ei);
    reg_sel = 2'd0; #1 check(req, "source", int'(reg_rdata), int'(es));
    reg_sel = 2'd1; #1 check(req, "pending", int'(reg_rdata), int'(ep));
    reg_sel = 2'd2; #1 check(req, "mask", int'(reg_rdata), int'(em));
    check(req, "irq", int'(irq_o), int'(ei));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual expired expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    reg_sel = 2'd0;
    idle_inputs();
    repeat (3) @(negedge clk);
    read_all("R9", 4'h0, 4'h0, 4'h0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [35:0] e;
      e = VEC[i];
      @(negedge clk);
      reg_wr_en = e[35]; reg_sel = e[34:33]; reg_wdata = e[32:29];
      evt_set = e[28:25]; fifo_en = e[24]; tx_level = e[23:21];
      tx_count = e[20:13];
      @(posedge clk);
      #1 idle_inputs();
      read_all(vtag(i), e[12:9], e[8:5], e[4:1], e[0]);
    end

    // R10: reserved select reads zero while registers hold data
    @(negedge clk);
    evt_set = 4'hA;
    @(posedge clk);
    #1 idle_inputs();
    reg_sel = 2'd3; #1 check("R10", "reserved read", int'(reg_rdata), 0);
    reg_sel = 2'd0; #1 check("R1", "error+modem held", int'(reg_rdata), 'hA);

    // R9: asynchronous reset mid-run
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 2'd2; reg_wdata = 4'h3;
    @(posedge clk);
    #1 idle_inputs();
    rst_n = 1'b0;
    #1 read_all("R9", 4'h0, 4'h0, 4'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    read_all("R9", 4'h0, 4'h0, 4'h0, 1'b0);

    finish_run();
  end
endmodule